// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel that moves data units from a source address to a destination address without processor involvement. Software sets up a transfer through a small write port. It chooses the unit size (8 or 16 bits) and gives the source and destination their own stepping modes: fixed, increment or decrement. It also picks the trigger line, loads both start addresses and the number of units, and then enables the channel.

Each trigger moves exactly one unit. The trigger is either a rising edge on the selected hardware request line or a software trigger bit. A unit is one read handshake on the read port followed by one write handshake on the write port. After each unit, both address registers step on their own and the unit counter drops by one. When the counter reaches zero, the channel raises a done flag, disables itself and ignores further triggers. While the channel is enabled, its configuration is frozen.

Top module: `xfer_engine`

Register write map (`cfgAddr`): 0 = mode, 1 = request select, 2 = source address, 3 = destination address, 4 = unit count, 5 = control (bit 0 enable, bit 1 software trigger).

## Requirements
- R1: After reset, every configuration output, `enOut`, `doneOut`, `rdValid` and `wrValid` is 0. The mode register holds bit 4 (0 = 8-bit, 1 = 16-bit), bits 3:2 (destination mode) and bits 1:0 (source mode). Bits 7:5 always read 0, so writing 8'hFF while disabled reads back 8'h1F.
- R2: Writes to mode, request select, source, destination and count take effect only while `enOut` is 0. While the channel is enabled, they leave those outputs unchanged.
- R3: A unit first holds `rdValid` with a stable address until `rdReady`, then holds `wrValid` until `wrReady`. `rdValid` and `wrValid` are never high together. The write carries the read data: all 16 bits for a 16-bit unit, and for an 8-bit unit the low byte with the upper byte driven as 0.
- R4: Mode code 00 (fixed) leaves that side's address register unchanged after a unit.
- R5: Mode code 01 (increment) adds 1 after an 8-bit unit and 2 after a 16-bit unit.
- R6: Mode codes 10 and 11 (decrement) both subtract 1 after an 8-bit unit and 2 after a 16-bit unit.
- R7: A 16-bit access drives address bit 0 as 0 on its port (`rdWide`/`wrWide` = 1). The internal register keeps its stepped value.
- R8: The 5-bit request select value N chooses `hwReq[N]`; for example, code 27 (11011) selects line 27. Only a 0-to-1 change of the selected line starts a unit. A held-high level and activity on other lines start nothing.
- R9: Writing control with bit 1 set while `enOut` is already 1 starts one unit. If the channel is disabled, the trigger is ignored.
- R10: A trigger that arrives while a unit is in progress is kept, and the next unit starts right after the current one completes.
- R11: The count drops by one per completed unit. When it is zero and the channel is idle, `doneOut` becomes 1, `enOut` becomes 0 and further triggers start nothing.
- R12: Writing control with bit 0 set clears `doneOut` on that edge. Enabling with a count of 0 completes on the following edge with no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register select |
| cfgWdata | input | 16 | Configuration write data |
| hwReq | input | 32 | Hardware request lines |
| rdValid | output | 1 | Read request valid |
| rdReady | input | 1 | Read data ready |
| rdAddr | output | 16 | Read address |
| rdWide | output | 1 | Read is a 16-bit access |
| rdData | input | 16 | Read data |
| wrValid | output | 1 | Write request valid |
| wrReady | input | 1 | Write accepted |
| wrAddr | output | 16 | Write address |
| wrWide | output | 1 | Write is a 16-bit access |
| wrData | output | 16 | Write data |
| modeOut | output | 8 | Mode register value |
| reqSelOut | output | 5 | Request select value |
| srcAddrOut | output | 16 | Source address register |
| dstAddrOut | output | 16 | Destination address register |
| countOut | output | 16 | Remaining unit count |
| enOut | output | 1 | Channel enabled |
| doneOut | output | 1 | Transfer complete flag |

## Verification
The main transfer runs under all 32 combinations of unit size, source mode and destination mode, with three units each. This distinguishes fixed, increment and decrement stepping, a step of 1 from a step of 2, the reserved decrement code, and the zeroed upper byte of 8-bit units. Source and destination run in different modes, so a swapped or shared step is exposed. Hardware triggering is tried with an unselected line, a held level, a fresh edge and an edge during a unit, which tells edge detection apart from level sensing and a dropped pending trigger. An odd wide address, a zero count and triggers after completion cover the boundaries.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } xferState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadData;  // read handshake completed, capture data
    logic advance;   // write handshake completed, step pointers and count
    logic finish;    // count exhausted: raise done, drop enable
  } xferStrobe_t;

  localparam logic [2:0] REG_MODE  = 3'd0;
  localparam logic [2:0] REG_RSEL  = 3'd1;
  localparam logic [2:0] REG_SRC   = 3'd2;
  localparam logic [2:0] REG_DST   = 3'd3;
  localparam logic [2:0] REG_COUNT = 3'd4;
  localparam logic [2:0] REG_CTRL  = 3'd5;

endpackage

// File: rtl/xfer_ptr.sv
module xfer_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          load,
  input  logic [AW-1:0] loadVal,
  input  logic          advance,
  input  logic [1:0]    mode,
  input  logic          wide,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] stride;
  assign stride = wide ? AW'(2) : AW'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr <= '0;
    end else if (load) begin
      addr <= loadVal;
    end else if (advance) begin
      case (mode)
        2'b00:   addr <= addr;
        2'b01:   addr <= addr + stride;
        default: addr <= addr - stride;  // 10 and reserved 11
      endcase
    end
  end
endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int REQ_LINES = 32,
  localparam int SW = $clog2(REQ_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [REQ_LINES-1:0] hwReq,
  input  logic [SW-1:0]        reqSel,
  input  logic                 en,
  input  logic                 countZero,
  input  logic                 swPulse,
  input  logic                 rdReady,
  input  logic                 wrReady,
  output logic                 rdValid,
  output logic                 wrValid,
  output xferStrobe_t          strobe
);
  xferState_t state, stateNext;
  logic linePrev, selLine, edgeHit, pending, startUnit;

  assign selLine   = hwReq[reqSel];
  assign edgeHit   = selLine & ~linePrev;
  assign startUnit = (state == ST_IDLE) && en && !countZero && pending;

  assign strobe.finish   = (state == ST_IDLE) && en && countZero;
  assign strobe.loadData = (state == ST_READ) && rdReady;
  assign strobe.advance  = (state == ST_WRITE) && wrReady;

  assign rdValid = (state == ST_READ);
  assign wrValid = (state == ST_WRITE);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (startUnit) stateNext = ST_READ;
      ST_READ:  if (rdReady)   stateNext = ST_WRITE;
      ST_WRITE: if (wrReady)   stateNext = ST_IDLE;
      default:                 stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      linePrev <= 1'b0;
      pending  <= 1'b0;
    end else begin
      state    <= stateNext;
      linePrev <= selLine;
      if (!en || strobe.finish)     pending <= 1'b0;
      else if (edgeHit || swPulse)  pending <= 1'b1;
      else if (startUnit)           pending <= 1'b0;
    end
  end
endmodule

// File: rtl/xfer_dp.sv
module xfer_dp
  import xfer_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16,
  parameter int SW = 5,
  localparam int WW = 16,
  localparam int BW = DW / 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [2:0]    cfgAddr,
  input  logic [WW-1:0] cfgWdata,
  input  xferStrobe_t   strobe,
  input  logic [DW-1:0] rdData,
  output logic [AW-1:0] rdAddr,
  output logic          rdWide,
  output logic [AW-1:0] wrAddr,
  output logic          wrWide,
  output logic [DW-1:0] wrData,
  output logic [7:0]    modeOut,
  output logic [SW-1:0] reqSel,
  output logic [AW-1:0] srcAddr,
  output logic [AW-1:0] dstAddr,
  output logic [CW-1:0] count,
  output logic          en,
  output logic          done,
  output logic          countZero,
  output logic          swPulse
);
  logic [4:0]    modeR;
  logic [DW-1:0] dataR;
  logic          wide, cfgOpen, ctrlWr;
  logic [AW-1:0] ptrAddr [2];
  logic [1:0]    ptrMode [2];
  logic          ptrLoad [2];

  assign wide      = modeR[4];
  assign cfgOpen   = cfgWe && !en;
  assign ctrlWr    = cfgWe && (cfgAddr == REG_CTRL);
  assign swPulse   = ctrlWr && cfgWdata[1] && en;
  assign countZero = (count == '0);
  assign modeOut   = {3'b000, modeR};

  assign ptrMode[0] = modeR[1:0];
  assign ptrMode[1] = modeR[3:2];

  for (genvar i = 0; i < 2; i++) begin : g_ptr
    assign ptrLoad[i] = cfgOpen && (cfgAddr == ((i == 0) ? REG_SRC : REG_DST));
    xfer_ptr #(.AW(AW)) u_ptr (
      .clk    (clk),
      .rstN   (rstN),
      .load   (ptrLoad[i]),
      .loadVal(cfgWdata[AW-1:0]),
      .advance(strobe.advance),
      .mode   (ptrMode[i]),
      .wide   (wide),
      .addr   (ptrAddr[i])
    );
  end

  assign srcAddr = ptrAddr[0];
  assign dstAddr = ptrAddr[1];
  assign rdAddr  = wide ? {srcAddr[AW-1:1], 1'b0} : srcAddr;
  assign wrAddr  = wide ? {dstAddr[AW-1:1], 1'b0} : dstAddr;
  assign rdWide  = wide;
  assign wrWide  = wide;
  assign wrData  = wide ? dataR : {{(DW-BW){1'b0}}, dataR[BW-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeR  <= '0;
      reqSel <= '0;
      count  <= '0;
      en     <= 1'b0;
      done   <= 1'b0;
      dataR  <= '0;
    end else begin
      if (strobe.loadData) dataR <= rdData;
      if (strobe.advance)  count <= count - 1'b1;
      if (cfgOpen) begin
        case (cfgAddr)
          REG_MODE:  modeR  <= cfgWdata[4:0];
          REG_RSEL:  reqSel <= cfgWdata[SW-1:0];
          REG_COUNT: count  <= cfgWdata[CW-1:0];
          default: ;
        endcase
      end
      if (strobe.finish) begin
        en   <= 1'b0;
        done <= 1'b1;
      end
      if (ctrlWr) begin
        en <= cfgWdata[0];
        if (cfgWdata[0]) done <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
  import xfer_pkg::*;
#(
  parameter int REQ_LINES = 32,
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16,
  localparam int SW = $clog2(REQ_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [2:0]           cfgAddr,
  input  logic [15:0]          cfgWdata,
  input  logic [REQ_LINES-1:0] hwReq,
  output logic                 rdValid,
  input  logic                 rdReady,
  output logic [AW-1:0]        rdAddr,
  output logic                 rdWide,
  input  logic [DW-1:0]        rdData,
  output logic                 wrValid,
  input  logic                 wrReady,
  output logic [AW-1:0]        wrAddr,
  output logic                 wrWide,
  output logic [DW-1:0]        wrData,
  output logic [7:0]           modeOut,
  output logic [SW-1:0]        reqSelOut,
  output logic [AW-1:0]        srcAddrOut,
  output logic [AW-1:0]        dstAddrOut,
  output logic [CW-1:0]        countOut,
  output logic                 enOut,
  output logic                 doneOut
);
  xferStrobe_t strobe;
  logic countZero, swPulse;

  xfer_ctrl #(.REQ_LINES(REQ_LINES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hwReq    (hwReq),
    .reqSel   (reqSelOut),
    .en       (enOut),
    .countZero(countZero),
    .swPulse  (swPulse),
    .rdReady  (rdReady),
    .wrReady  (wrReady),
    .rdValid  (rdValid),
    .wrValid  (wrValid),
    .strobe   (strobe)
  );

  xfer_dp #(.AW(AW), .CW(CW), .DW(DW), .SW(SW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgWdata (cfgWdata),
    .strobe   (strobe),
    .rdData   (rdData),
    .rdAddr   (rdAddr),
    .rdWide   (rdWide),
    .wrAddr   (wrAddr),
    .wrWide   (wrWide),
    .wrData   (wrData),
    .modeOut  (modeOut),
    .reqSel   (reqSelOut),
    .srcAddr  (srcAddrOut),
    .dstAddr  (dstAddrOut),
    .count    (countOut),
    .en       (enOut),
    .done     (doneOut),
    .countZero(countZero),
    .swPulse  (swPulse)
  );
endmodule

// File: rtl/xfer_checks.sv
module xfer_checks #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          cfgWe,
  input logic [2:0]    cfgAddr,
  input logic          rdValid,
  input logic          rdReady,
  input logic [AW-1:0] rdAddr,
  input logic          rdWide,
  input logic          wrValid,
  input logic          wrReady,
  input logic [AW-1:0] wrAddr,
  input logic          wrWide,
  input logic [7:0]    modeOut,
  input logic [AW-1:0] srcAddrOut,
  input logic [CW-1:0] countOut,
  input logic          enOut,
  input logic          doneOut
);
  p_lock_mode_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enOut && cfgWe && cfgAddr == 3'd0) |=> $stable(modeOut));

  p_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(rdValid && wrValid));

  p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdAddr)));

  p_fixed_src_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enOut && wrValid && wrReady && modeOut[1:0] == 2'b00) |=> $stable(srcAddrOut));

  p_inc_src_r5: assert property (@(posedge clk) disable iff (!rstN)
    (enOut && wrValid && wrReady && modeOut[1:0] == 2'b01) |=>
      (srcAddrOut == $past(srcAddrOut) + ($past(modeOut[4]) ? AW'(2) : AW'(1))));

  p_rd_even_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdWide) |-> !rdAddr[0]);

  p_wr_even_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrWide) |-> !wrAddr[0]);

  p_count_step_r11: assert property (@(posedge clk) disable iff (!rstN)
    (enOut && wrValid && wrReady) |=> (countOut == $past(countOut) - 1'b1));

  p_done_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> !enOut);
endmodule

bind xfer_engine xfer_checks #(.AW(AW), .CW(CW)) u_checks (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWe     (cfgWe),
  .cfgAddr   (cfgAddr),
  .rdValid   (rdValid),
  .rdReady   (rdReady),
  .rdAddr    (rdAddr),
  .rdWide    (rdWide),
  .wrValid   (wrValid),
  .wrReady   (wrReady),
  .wrAddr    (wrAddr),
  .wrWide    (wrWide),
  .modeOut   (modeOut),
  .srcAddrOut(srcAddrOut),
  .countOut  (countOut),
  .enOut     (enOut),
  .doneOut   (doneOut)
);

// File: tb/xfer_engine_bench.sv
`timescale 1ns/1ps
module xfer_engine_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [15:0] cfgWdata = '0;
  logic [31:0] hwReq = '0;
  logic        rdValid, rdWide, wrValid, wrWide, enOut, doneOut;
  logic        rdReady = 1'b0;
  logic        wrReady = 1'b0;
  logic [15:0] rdData = '0;
  logic [15:0] rdAddr, wrAddr, wrData, srcAddrOut, dstAddrOut, countOut;
  logic [7:0]  modeOut;
  logic [4:0]  reqSelOut;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  xfer_engine u_xfer_engine (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .hwReq(hwReq), .rdValid(rdValid), .rdReady(rdReady), .rdAddr(rdAddr),
    .rdWide(rdWide), .rdData(rdData), .wrValid(wrValid), .wrReady(wrReady),
    .wrAddr(wrAddr), .wrWide(wrWide), .wrData(wrData), .modeOut(modeOut),
    .reqSelOut(reqSelOut), .srcAddrOut(srcAddrOut), .dstAddrOut(dstAddrOut),
    .countOut(countOut), .enOut(enOut), .doneOut(doneOut)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] a, input logic [1:0] m, input bit w);
    logic [15:0] s = w ? 16'd2 : 16'd1;
    if (m == 2'b00) return a;
    if (m == 2'b01) return a + s;
    return a - s;
  endfunction

  function automatic logic [15:0] mem(input logic [15:0] a);
    return (a * 16'd97) ^ 16'hA5C3;
  endfunction

  // no unit may start over n cycles
  task automatic quiet(input int n, input string req);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rdValid || wrValid) seen = 1;
    end
    chk(!seen, req, 32'(seen), 32'd0);
  endtask

  // serve one unit; expSrc/expDst are the port addresses expected
  task automatic serveUnit(input logic [15:0] expSrc, input logic [15:0] expDst,
                           input bit w, input string req);
    int n = 0;
    logic [15:0] word;
    while (!rdValid && n < 40) begin @(negedge clk); n++; end
    chk(rdValid, req, 32'(rdValid), 32'd1);
    chk(!wrValid, "R3", 32'(wrValid), 32'd0);
    chk(rdAddr == expSrc, req, 32'(rdAddr), 32'(expSrc));
    chk(rdWide == w, "R7", 32'(rdWide), 32'(w));
    word = mem(expSrc);
    rdData = word; rdReady = 1'b1;
    @(negedge clk);
    rdReady = 1'b0; rdData = '0;
    n = 0;
    while (!wrValid && n < 40) begin @(negedge clk); n++; end
    chk(wrValid && !rdValid, "R3", 32'(wrValid), 32'd1);
    chk(wrAddr == expDst, req, 32'(wrAddr), 32'(expDst));
    chk(wrData == (w ? word : {8'h00, word[7:0]}), "R3", 32'(wrData),
        32'(w ? word : {8'h00, word[7:0]}));
    wrReady = 1'b1;
    @(negedge clk);
    wrReady = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(modeOut == 8'h00 && reqSelOut == 5'd0 && countOut == 16'd0, "R1",
        {8'h0, modeOut, countOut}, 32'd0);
    chk(!enOut && !doneOut && !rdValid && !wrValid, "R1",
        {enOut, doneOut, rdValid, wrValid}, 32'd0);
    writeReg(3'd0, 16'h00FF);
    chk(modeOut == 8'h1F, "R1", 32'(modeOut), 32'h1F);

    // sweep: unit size x source mode x destination mode
    for (int cfg = 0; cfg < 32; cfg++) begin
      logic [15:0] s, d;
      bit w;
      logic [1:0] sm, dm;
      string req;
      w = cfg[4]; dm = cfg[3:2]; sm = cfg[1:0];
      req = (sm == 2'b00) ? "R4" : (sm == 2'b01) ? "R5" : "R6";
      s = 16'h0130; d = 16'h0A40;
      writeReg(3'd0, 16'(cfg));
      writeReg(3'd2, s);
      writeReg(3'd3, d);
      writeReg(3'd4, 16'd3);
      writeReg(3'd5, 16'h0001);
      if (cfg == 0) chk(!doneOut && enOut, "R12", {doneOut, enOut}, 32'd1);
      if (cfg == 5) begin
        writeReg(3'd0, 16'h0017);
        writeReg(3'd2, 16'h7777);
        writeReg(3'd1, 16'h0009);
        chk(modeOut == 8'h05 && srcAddrOut == s && reqSelOut == 5'd0, "R2",
            {modeOut, srcAddrOut}, {8'h05, s});
      end
      for (int u = 0; u < 3; u++) begin
        writeReg(3'd5, 16'h0003);
        serveUnit(s, d, w, "R9");
        s = nxt(s, sm, w);
        d = nxt(d, dm, w);
        chk(srcAddrOut == s, req, 32'(srcAddrOut), 32'(s));
        chk(dstAddrOut == d, "R5", 32'(dstAddrOut), 32'(d));
        chk(countOut == 16'(2 - u), "R11", 32'(countOut), 32'(2 - u));
      end
      @(negedge clk); @(negedge clk);
      chk(doneOut && !enOut, "R11", {doneOut, enOut}, 32'd2);
    end

    // R2: writes accepted while disabled
    writeReg(3'd2, 16'h0055);
    chk(srcAddrOut == 16'h0055, "R2", 32'(srcAddrOut), 32'h55);

    // R9 / R11: triggers after completion start nothing
    writeReg(3'd5, 16'h0002);
    quiet(8, "R9");
    hwReq[0] = 1'b1;
    quiet(6, "R11");
    hwReq[0] = 1'b0;

    // R7: odd start address, 16-bit increment
    writeReg(3'd0, 16'h0011);
    writeReg(3'd2, 16'h0131);
    writeReg(3'd3, 16'h0243);
    writeReg(3'd4, 16'd1);
    writeReg(3'd5, 16'h0001);
    writeReg(3'd5, 16'h0003);
    serveUnit(16'h0130, 16'h0242, 1'b1, "R7");
    chk(srcAddrOut == 16'h0133, "R7", 32'(srcAddrOut), 32'h133);

    // R8 / R10: hardware requests on line 27 (code 11011)
    writeReg(3'd0, 16'h0005);
    writeReg(3'd1, 16'd27);
    writeReg(3'd2, 16'h0010);
    writeReg(3'd3, 16'h0020);
    writeReg(3'd4, 16'd4);
    writeReg(3'd5, 16'h0001);
    chk(!doneOut, "R12", 32'(doneOut), 32'd0);
    @(negedge clk); hwReq[5] = 1'b1;
    quiet(8, "R8");
    hwReq[5] = 1'b0;
    hwReq[27] = 1'b1;
    serveUnit(16'h0010, 16'h0020, 1'b0, "R8");
    quiet(8, "R8");
    chk(countOut == 16'd3, "R8", 32'(countOut), 32'd3);
    hwReq[27] = 1'b0;
    @(negedge clk); hwReq[27] = 1'b1;
    for (int i = 0; i < 40 && !rdValid; i++) @(negedge clk);
    hwReq[27] = 1'b0;
    @(negedge clk); hwReq[27] = 1'b1;
    @(negedge clk);
    serveUnit(16'h0011, 16'h0021, 1'b0, "R8");
    serveUnit(16'h0012, 16'h0022, 1'b0, "R10");
    chk(countOut == 16'd1, "R10", 32'(countOut), 32'd1);
    hwReq[27] = 1'b0;
    writeReg(3'd5, 16'h0000);

    // R12: enable with zero count
    writeReg(3'd4, 16'd0);
    writeReg(3'd5, 16'h0001);
    chk(enOut && !doneOut, "R12", {enOut, doneOut}, 32'd2);
    @(negedge clk);
    chk(doneOut && !enOut && !rdValid, "R12", {doneOut, enOut, rdValid}, 32'd2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule